// File: doc/BRIEF.md
# Configuration Transaction Controller

This block runs single-shot configuration commands for a board-level control space. Software loads a 32-bit value into the DATA window and then writes a command word to the CMD window. If that word has its start bit set, the controller decodes the command fields in the same clock edge. It then does one of two things: it fetches a parameter (an oscillator frequency or a supply voltage) into DATA, or it commits DATA into an oscillator entry. The outcome goes into the STAT window. Unsupported selectors set an error flag and touch nothing else.

The controller keeps a motherboard oscillator table with six entries and a daughterboard oscillator table. The daughterboard table's size and reset contents come from parameters. A separate daughterboard voltage table is fixed by parameters. Two write functions emit one-cycle request pulses, one for system shutdown and one for system reboot. Every transaction has finished by the clock edge that stores the command. A bus read of STAT or DATA in the following cycle therefore returns the result.

Top module: `cfgx_ctrl`

## Requirements
- R1: After reset, DATA, CMD and STAT read 0, and both request outputs are low. Oscillator entries return to their reset frequencies: motherboard entries 0..5 are 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000, and daughterboard entries take the values of the DB_OSC_INIT parameter.
- R2: The CMD window (offset 0xA4) stores the written word with bit 31 and bits 19:18 forced to 0. The command fields are: bit 31 start, bit 30 direction (1 write, 0 read), bits 29:26 controller number, bits 25:20 function, bits 17:16 site, bits 15:12 stack position, and bits 11:0 device.
- R3: A CMD write with start set leaves STAT (offset 0xA8) with bit 0 = 1 (done), readable in the next cycle.
- R4: A command whose controller number or position is nonzero, whose site is 2 or 3, or whose function is unsupported sets STAT to 3 (done plus error bit 1) and causes no other effect.
- R5: A read of function 1 returns motherboard oscillator entry 0..5 into DATA when site is 0, or daughterboard entry dev into DATA when site is 1 and dev < DB_OSC_N. An index outside these ranges is an error.
- R6: A write of function 1 with a valid site and device stores DATA into the selected oscillator entry. A later read of that entry returns the stored value.
- R7: Function 2 is read-only. Site 0 with device 0 returns 3300000. Site 1 with dev < DB_VOLT_N returns entry dev of DB_VOLT. Every other voltage selector, and any write of function 2, is an error.
- R8: Writes of functions 7, 8, 9 and 11 succeed only at site 0, device 0. Function 8 raises shutdown_req and function 9 raises reboot_req, each for exactly one cycle after the CMD write. Reads of these functions, and other sites or devices, are errors.
- R9: A bus write to STAT stores only bits 1:0 of the written data.
- R10: DATA (offset 0xA0) is a plain read/write register. A failed read command leaves it unchanged.
- R11: A CMD write with start clear stores the command but leaves STAT, DATA and the outputs unchanged.
- R12: Unmapped offsets read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| shutdown_req | output | 1 | One-cycle shutdown request pulse |
| reboot_req | output | 1 | One-cycle reboot request pulse |

## Verification
The hardest condition to reach from the ports is a committed oscillator value that survives later traffic. Reaching it takes four bus operations in order: load DATA, issue a write command, clear DATA, then issue a read command. Only the final DATA value shows whether the commit happened. The vector table chains these steps for a motherboard entry and for a daughterboard entry. Error cases are checked twice, once in STAT and once by confirming that DATA still holds the value from before the failed read.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    localparam int DW = 32;
    localparam int AW = 12;
    localparam logic [AW-1:0] OFF_DATA = 12'hA0;
    localparam logic [AW-1:0] OFF_CMD  = 12'hA4;
    localparam logic [AW-1:0] OFF_STAT = 12'hA8;
    localparam logic [DW-1:0] CMD_KEEP = 32'h7FF3_FFFF;
    localparam int MB_OSC_N = 6;
    localparam logic [DW-1:0] MB_VOLT = 32'd3300000;

    localparam logic [5:0] FN_OSC  = 6'd1;
    localparam logic [5:0] FN_VOLT = 6'd2;
    localparam logic [5:0] FN_VMUX = 6'd7;
    localparam logic [5:0] FN_SHUT = 6'd8;
    localparam logic [5:0] FN_BOOT = 6'd9;
    localparam logic [5:0] FN_DISP = 6'd11;

    typedef struct packed {
        logic        start;
        logic        write;
        logic [3:0]  unit;
        logic [5:0]  func;
        logic [1:0]  gap;
        logic [1:0]  site;
        logic [3:0]  pos;
        logic [11:0] dev;
    } cmd_t;

    function automatic logic [DW-1:0] mb_osc_reset(input int idx);
        case (idx)
            0:       return 32'd50000000;
            1:       return 32'd23750000;
            default: return 32'd24000000;
        endcase
    endfunction
endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
#(
    parameter int DB_OSC_N  = 2,
    parameter int DB_VOLT_N = 2,
    localparam int OSC_N  = MB_OSC_N + DB_OSC_N,
    localparam int OIW    = $clog2(OSC_N),
    localparam int VIW    = (DB_VOLT_N > 1) ? $clog2(DB_VOLT_N) : 1
) (
    input  cmd_t           cmd,
    output logic           legal,
    output logic           osc_hit,
    output logic [OIW-1:0] osc_idx,
    output logic           volt_mb,
    output logic           volt_db,
    output logic [VIW-1:0] volt_idx,
    output logic           fire_shut,
    output logic           fire_boot
);
    logic        base_ok;
    logic        at_mb;
    logic        at_db;
    logic        mb_dev0;
    logic        osc_sel;
    logic        sys_fn;
    logic [11:0] flat;

    always_comb begin
        base_ok  = (cmd.unit == 4'd0) && (cmd.pos == 4'd0) && (cmd.site[1] == 1'b0);
        at_mb    = base_ok && (cmd.site[0] == 1'b0);
        at_db    = base_ok && cmd.site[0];
        mb_dev0  = at_mb && (cmd.dev == 12'd0);
        osc_sel  = (cmd.func == FN_OSC) &&
                   ((at_mb && (cmd.dev < 12'(MB_OSC_N))) ||
                    (at_db && (cmd.dev < 12'(DB_OSC_N))));
        volt_mb  = !cmd.write && (cmd.func == FN_VOLT) && mb_dev0;
        volt_db  = !cmd.write && (cmd.func == FN_VOLT) && at_db &&
                   (cmd.dev < 12'(DB_VOLT_N));
        sys_fn   = cmd.write && mb_dev0 &&
                   ((cmd.func == FN_VMUX) || (cmd.func == FN_SHUT) ||
                    (cmd.func == FN_BOOT) || (cmd.func == FN_DISP));
        fire_shut = sys_fn && (cmd.func == FN_SHUT);
        fire_boot = sys_fn && (cmd.func == FN_BOOT);
        osc_hit  = osc_sel;
        flat     = cmd.site[0] ? (cmd.dev + 12'(MB_OSC_N)) : cmd.dev;
        osc_idx  = flat[OIW-1:0];
        volt_idx = cmd.dev[VIW-1:0];
        legal    = osc_sel || volt_mb || volt_db || sys_fn;
    end
endmodule

// File: rtl/cfgx_osc_bank.sv
module cfgx_osc_bank
    import cfgx_pkg::*;
#(
    parameter int DB_OSC_N = 2,
    parameter logic [DB_OSC_N*DW-1:0] DB_OSC_INIT = '0,
    localparam int OSC_N = MB_OSC_N + DB_OSC_N,
    localparam int OIW   = $clog2(OSC_N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [OIW-1:0] idx,
    input  logic [DW-1:0]  wr_val,
    output logic [DW-1:0]  rd_val
);
    logic [DW-1:0] tab_d [OSC_N];
    logic [DW-1:0] tab_q [OSC_N];

    always_comb begin
        for (int i = 0; i < OSC_N; i++) begin
            tab_d[i] = (wr_en && (32'(idx) == i)) ? wr_val : tab_q[i];
        end
        rd_val = '0;
        for (int i = 0; i < OSC_N; i++) begin
            if (32'(idx) == i) rd_val = tab_q[i];
        end
    end

    for (genvar g = 0; g < OSC_N; g++) begin : g_ent
        localparam logic [DW-1:0] RST_VAL = (g < MB_OSC_N) ? mb_osc_reset(g)
                                   : DB_OSC_INIT[((g >= MB_OSC_N) ? g - MB_OSC_N : 0)*DW +: DW];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tab_q[g] <= RST_VAL;
            else        tab_q[g] <= tab_d[g];
        end
    end
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
    import cfgx_pkg::*;
#(
    parameter int DB_OSC_N  = 2,
    parameter int DB_VOLT_N = 2,
    parameter logic [DB_OSC_N*32-1:0]  DB_OSC_INIT = {32'd60000000, 32'd45000000},
    parameter logic [DB_VOLT_N*32-1:0] DB_VOLT     = {32'd1800000, 32'd1000000},
    localparam int OSC_N = MB_OSC_N + DB_OSC_N,
    localparam int OIW   = $clog2(OSC_N),
    localparam int VIW   = (DB_VOLT_N > 1) ? $clog2(DB_VOLT_N) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        shutdown_req,
    output logic        reboot_req
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic [DW-1:0] cmd;
        logic [1:0]    stat;
        logic          shut;
        logic          boot;
    } st_t;

    st_t st_d, st_q;

    cmd_t           wcmd;
    logic           legal, osc_hit, volt_mb, volt_db, fire_shut, fire_boot;
    logic [OIW-1:0] osc_idx;
    logic [VIW-1:0] volt_idx;
    logic           osc_we;
    logic [DW-1:0]  osc_val;
    logic [DW-1:0]  fetch;

    assign wcmd = cmd_t'(bus_wdata);

    cfgx_decode #(.DB_OSC_N(DB_OSC_N), .DB_VOLT_N(DB_VOLT_N)) u_dec (
        .cmd(wcmd), .legal(legal), .osc_hit(osc_hit), .osc_idx(osc_idx),
        .volt_mb(volt_mb), .volt_db(volt_db), .volt_idx(volt_idx),
        .fire_shut(fire_shut), .fire_boot(fire_boot)
    );

    cfgx_osc_bank #(.DB_OSC_N(DB_OSC_N), .DB_OSC_INIT(DB_OSC_INIT)) u_osc (
        .clk(clk), .rst_n(rst_n), .wr_en(osc_we), .idx(osc_idx),
        .wr_val(st_q.data), .rd_val(osc_val)
    );

    always_comb begin
        if (osc_hit)      fetch = osc_val;
        else if (volt_mb) fetch = MB_VOLT;
        else if (volt_db) fetch = DB_VOLT[32'(volt_idx)*DW +: DW];
        else              fetch = '0;
    end

    always_comb begin
        st_d      = st_q;
        st_d.shut = 1'b0;
        st_d.boot = 1'b0;
        osc_we    = 1'b0;
        if (bus_we) begin
            case (bus_addr)
                OFF_DATA: st_d.data = bus_wdata;
                OFF_STAT: st_d.stat = bus_wdata[1:0];
                OFF_CMD: begin
                    st_d.cmd = bus_wdata & CMD_KEEP;
                    if (wcmd.start) begin
                        st_d.stat = {!legal, 1'b1};
                        if (legal && wcmd.write) begin
                            osc_we    = osc_hit;
                            st_d.shut = fire_shut;
                            st_d.boot = fire_boot;
                        end else if (legal) begin
                            st_d.data = fetch;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            OFF_DATA: bus_rdata = st_q.data;
            OFF_CMD:  bus_rdata = st_q.cmd;
            OFF_STAT: bus_rdata = {30'd0, st_q.stat};
            default:  bus_rdata = '0;
        endcase
    end

    assign shutdown_req = st_q.shut;
    assign reboot_req   = st_q.boot;
endmodule

// File: rtl/cfgx_ctrl_chk.sv
module cfgx_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        shutdown_req,
    input logic        reboot_req,
    input logic [1:0]  stat,
    input logic [31:0] data
);
    logic go;
    assign go = bus_we && (bus_addr == 12'hA4) && bus_wdata[31];

    // R2
    cmd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 12'hA4) |-> (bus_rdata[31] == 1'b0 && bus_rdata[19:18] == 2'b00));

    // R3
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> stat[0]);

    // R4
    bad_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && bus_wdata[29:26] != 4'd0) |=> (stat == 2'b11));

    // R8
    shut_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(go && bus_wdata[30] && bus_wdata[25:20] == 6'd8));

    // R8
    shut_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> !shutdown_req);

    // R8
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(shutdown_req && reboot_req));

    // R9
    stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 12'hA8) |=> (stat == $past(bus_wdata[1:0])));

    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !bus_wdata[30] && bus_wdata[15:12] != 4'd0) |=> $stable(data));
endmodule

bind cfgx_ctrl cfgx_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .shutdown_req(shutdown_req),
    .reboot_req(reboot_req), .stat(st_q.stat), .data(st_q.data)
);

// File: tb/tb_cfgx_ctrl.sv
module tb_cfgx_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        shutdown_req, reboot_req;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cfgx_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .shutdown_req(shutdown_req), .reboot_req(reboot_req)
    );

    typedef struct packed {
        logic        rd;
        logic [11:0] addr;
        logic [31:0] dat;
        logic [7:0]  req;
    } vec_t;

    function automatic logic [31:0] cmd(input logic wr, input int unit, input int fn,
                                        input int site, input int pos, input int dev);
        return {1'b1, wr, 4'(unit), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
    endfunction
    function automatic vec_t W(input logic [11:0] a, input logic [31:0] d, input int r);
        return {1'b0, a, d, 8'(r)};
    endfunction
    function automatic vec_t R(input logic [11:0] a, input logic [31:0] e, input int r);
        return {1'b1, a, e, 8'(r)};
    endfunction

    localparam int NV = 67;
    localparam vec_t VEC [NV] = '{
        R(12'hA0, 0, 1), R(12'hA4, 0, 1), R(12'hA8, 0, 1),                  // R1
        W(12'hA4, 32'hFFFF_FFFF, 2), R(12'hA4, 32'h7FF3_FFFF, 2),          // R2
        R(12'hA8, 3, 4),                                                     // R4
        W(12'hA4, cmd(0,0,1,0,0,0), 5), R(12'hA0, 50000000, 5),              // R5
        R(12'hA8, 1, 3),                                                     // R3
        W(12'hA4, cmd(0,0,1,0,0,1), 5), R(12'hA0, 23750000, 5),
        W(12'hA4, cmd(0,0,1,0,0,5), 5), R(12'hA0, 24000000, 5),
        W(12'hA4, cmd(0,0,1,1,0,1), 5), R(12'hA0, 60000000, 5),
        W(12'hA4, cmd(0,0,1,1,0,2), 5), R(12'hA8, 3, 5),
        R(12'hA0, 60000000, 10),                                             // R10
        W(12'hA4, cmd(0,0,1,0,0,6), 5), R(12'hA8, 3, 5),
        W(12'hA0, 12345678, 6), W(12'hA4, cmd(1,0,1,0,0,3), 6),              // R6
        R(12'hA8, 1, 6), W(12'hA0, 0, 10), R(12'hA0, 0, 10),
        W(12'hA4, cmd(0,0,1,0,0,3), 6), R(12'hA0, 12345678, 6),
        W(12'hA0, 777, 6), W(12'hA4, cmd(1,0,1,1,0,0), 6), W(12'hA0, 0, 6),
        W(12'hA4, cmd(0,0,1,1,0,0), 6), R(12'hA0, 777, 6),
        W(12'hA4, cmd(0,0,2,0,0,0), 7), R(12'hA0, 3300000, 7),               // R7
        W(12'hA4, cmd(0,0,2,1,0,1), 7), R(12'hA0, 1800000, 7),
        W(12'hA4, cmd(0,0,2,1,0,2), 7), R(12'hA8, 3, 7),
        W(12'hA4, cmd(1,0,2,0,0,0), 7), R(12'hA8, 3, 7),
        W(12'hA4, cmd(0,1,1,0,0,0), 4), R(12'hA8, 3, 4),                     // R4
        W(12'hA4, cmd(0,0,1,0,1,0), 4), R(12'hA8, 3, 4),
        W(12'hA4, cmd(0,0,1,2,0,0), 4), R(12'hA8, 3, 4),
        W(12'hA4, cmd(0,0,3,0,0,0), 4), R(12'hA8, 3, 4),
        W(12'hA4, cmd(1,0,7,0,0,0), 8), R(12'hA8, 1, 8),                     // R8
        W(12'hA4, cmd(1,0,11,0,0,0), 8), R(12'hA8, 1, 8),
        W(12'hA4, cmd(1,0,7,0,0,1), 8), R(12'hA8, 3, 8),
        W(12'hA4, cmd(0,0,8,0,0,0), 8), R(12'hA8, 3, 8),
        W(12'hA8, 32'hFFFF_FFFE, 9), R(12'hA8, 2, 9),                        // R9
        W(12'hA0, 5, 11), W(12'hA8, 0, 11), W(12'hA4, 32'h0010_0000, 11),    // R11
        R(12'hA0, 5, 11), R(12'hA8, 0, 11), R(12'hA4, 32'h0010_0000, 2),
        W(12'h010, 32'h0000_FFFF, 12), R(12'h010, 0, 12), R(12'hA0, 5, 12)   // R12
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input int req);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1 check(req, bus_rdata, e, $sformatf("read 0x%03h", a));
    endtask

    task automatic pulse_test(input logic [31:0] c, input logic es, input logic eb);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 12'hA4; bus_wdata = c;
        @(posedge clk); #1;
        check(8, {31'd0, shutdown_req}, {31'd0, es}, "shutdown_req pulse");
        check(8, {31'd0, reboot_req}, {31'd0, eb}, "reboot_req pulse");
        @(negedge clk); bus_we = 1'b0;
        @(posedge clk); #1;
        check(8, {30'd0, shutdown_req, reboot_req}, 32'd0, "pulse end");
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 request outputs low out of reset
        #1 check(1, {30'd0, shutdown_req, reboot_req}, 32'd0, "reset outputs");
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) rd(VEC[i].addr, VEC[i].dat, int'(VEC[i].req));
            else           wr(VEC[i].addr, VEC[i].dat);
        end
        // R8 request pulses
        pulse_test(cmd(1,0,8,0,0,0), 1'b1, 1'b0);
        pulse_test(cmd(1,0,9,0,0,0), 1'b0, 1'b1);
        pulse_test(cmd(1,0,8,1,0,0), 1'b0, 1'b0);
        pulse_test(cmd(0,0,9,0,0,0), 1'b0, 1'b0);
        // R1 reset restores table and clears registers
        wr(12'hA0, 99);
        wr(12'hA4, cmd(1,0,1,0,0,0));
        wr(12'hA4, cmd(1,0,1,1,0,1));
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(12'hA0, 0, 1);
        rd(12'hA8, 0, 1);
        rd(12'hA4, 0, 1);
        wr(12'hA4, cmd(0,0,1,0,0,0));
        rd(12'hA0, 50000000, 1);
        wr(12'hA4, cmd(0,0,1,1,0,1));
        rd(12'hA0, 60000000, 1);
        wr(12'hA4, cmd(0,0,1,1,0,0));
        rd(12'hA0, 45000000, 1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule